// File: doc/BRIEF.md
# UART FIFO Interrupt Trigger Selector

This block decides when the receive and transmit FIFOs of a UART with 64-entry FIFOs have crossed their interrupt trigger levels. It holds one 8-bit configuration register made of two 4-bit fields, one per direction, each giving a level in units of four entries. A field of zero hands control back to a coarse 2-bit choice supplied by the FIFO control logic. A nonzero field replaces that choice, so levels from 4 to 60 in steps of four become available. Each direction makes this choice on its own.

The receive condition compares the number of characters held in the receive FIFO with its selected level. The transmit condition compares the number of free spaces in the transmit FIFO with its own level. Both conditions are combinational functions of the register and the live counts, so they follow the FIFOs with no added latency. The register accepts a write only while two separate enable bits held elsewhere in the UART are both set. Interrupt priority and the FIFOs themselves belong to other blocks.

Top module: `uart_fifo_trig_sel`

## Requirements
- R1: After reset the register holds zero in both fields, so the fallback levels chosen by `rx_fsel` and `tx_fsel` apply.
- R2: Bits 7:4 of the register are the receive field and bits 3:0 are the transmit field; a nonzero field value F selects a level of 4*F entries.
- R3: When the receive field is nonzero, its level is used and `rx_fsel` has no effect on `rx_trig`.
- R4: When the transmit field is nonzero, its level is used and `tx_fsel` has no effect on `tx_trig`; each direction chooses independently of the other's field.
- R5: With a zero receive field, `rx_fsel` codes 00, 01, 10, 11 select levels of 8, 16, 56 and 60 characters.
- R6: With a zero transmit field, `tx_fsel` codes 00, 01, 10, 11 select levels of 8, 16, 32 and 56 free spaces.
- R7: `rx_trig` is 1 exactly while `rx_count` is at or above the selected receive level, in the same cycle as the count.
- R8: `tx_trig` is 1 exactly while `tx_space` is at or above the selected transmit level, in the same cycle as the count.
- R9: A write is taken only when `cfg_wr`, `feat_en` and `bank_sel` are all 1 at a rising clock edge; any other write attempt leaves the register unchanged.
- R10: An accepted write changes the triggers from the clock edge at which it is sampled onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the trigger register |
| cfg_wdata | input | 8 | Write data: receive field in 7:4, transmit field in 3:0 |
| feat_en | input | 1 | First write-enable condition from the UART's feature register |
| bank_sel | input | 1 | Second write-enable condition from the UART's modem control register |
| rx_fsel | input | 2 | Fallback receive level code |
| tx_fsel | input | 2 | Fallback transmit level code |
| rx_count | input | 7 | Characters held in the receive FIFO (0 to 64) |
| tx_space | input | 7 | Free spaces in the transmit FIFO (0 to 64) |
| rx_trig | output | 1 | Receive trigger condition |
| tx_trig | output | 1 | Transmit trigger condition |

## Verification
The trigger outputs are due in the same cycle as any change of `rx_count`, `tx_space`, `rx_fsel` or `tx_fsel`, since no register lies on those paths. A register write is due one edge later: it is sampled at the rising edge and its new levels act on the outputs right after that edge. The bench therefore drives every input at the falling edge, updates its own copy of the register at the rising edge from the same gated write rule, and compares both outputs shortly after each falling edge, when both the live inputs and any write from the edge before are in effect.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } uft_dir_e;

  // Fallback level for a 2-bit code, per direction.
  function automatic int unsigned fallback_level(uft_dir_e dir, logic [1:0] code);
    int unsigned lvl;
    if (dir == DIR_RX) begin
      case (code)
        2'b00:   lvl = 8;
        2'b01:   lvl = 16;
        2'b10:   lvl = 56;
        default: lvl = 60;
      endcase
    end else begin
      case (code)
        2'b00:   lvl = 8;
        2'b01:   lvl = 16;
        2'b10:   lvl = 32;
        default: lvl = 56;
      endcase
    end
    return lvl;
  endfunction

endpackage

// File: rtl/uft_cfg_reg.sv
module uft_cfg_reg #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             unlock_a,
  input  logic             unlock_b,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] cfg_q
);

  logic             accept;
  logic [REG_W-1:0] cfg_d;

  always_comb begin
    accept = wr & unlock_a & unlock_b;
    cfg_d  = cfg_q;
    if (accept) begin
      cfg_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (accept) begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/uft_trig_unit.sv
module uft_trig_unit
  import uft_pkg::*;
#(
  parameter uft_dir_e DIR     = DIR_RX,
  parameter int       FIELD_W = 4,
  parameter int       UNIT    = 4,
  parameter int       CNT_W   = 7
) (
  input  logic [FIELD_W-1:0] field,
  input  logic [1:0]         fsel,
  input  logic [CNT_W-1:0]   count,
  output logic               trig
);

  logic [CNT_W-1:0] lvl_fb;
  logic [CNT_W-1:0] lvl_prog;
  logic [CNT_W-1:0] lvl_sel;
  logic             use_prog;

  generate
    if (DIR == DIR_RX) begin : g_rx_fb
      always_comb lvl_fb = CNT_W'(fallback_level(DIR_RX, fsel));
    end else begin : g_tx_fb
      always_comb lvl_fb = CNT_W'(fallback_level(DIR_TX, fsel));
    end
  endgenerate

  always_comb begin
    use_prog = |field;
    lvl_prog = CNT_W'(field) * CNT_W'(UNIT);
    lvl_sel  = use_prog ? lvl_prog : lvl_fb;
    trig     = (count >= lvl_sel);
  end

endmodule

// File: rtl/uart_fifo_trig_sel.sv
module uart_fifo_trig_sel
  import uft_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int FIELD_W    = 4,
  parameter int UNIT       = 4,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [2*FIELD_W-1:0] cfg_wdata,
  input  logic                 feat_en,
  input  logic                 bank_sel,
  input  logic [1:0]           rx_fsel,
  input  logic [1:0]           tx_fsel,
  input  logic [CNT_W-1:0]     rx_count,
  input  logic [CNT_W-1:0]     tx_space,
  output logic                 rx_trig,
  output logic                 tx_trig
);

  localparam int REG_W = 2 * FIELD_W;

  logic [REG_W-1:0]   trig_cfg_q;
  logic [FIELD_W-1:0] rx_field;
  logic [FIELD_W-1:0] tx_field;

  uft_cfg_reg #(.REG_W(REG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .unlock_a (feat_en),
    .unlock_b (bank_sel),
    .wdata    (cfg_wdata),
    .cfg_q    (trig_cfg_q)
  );

  // Receive field in the upper half, transmit field in the lower half.
  assign rx_field = trig_cfg_q[REG_W-1:FIELD_W];
  assign tx_field = trig_cfg_q[FIELD_W-1:0];

  uft_trig_unit #(.DIR(DIR_RX), .FIELD_W(FIELD_W), .UNIT(UNIT), .CNT_W(CNT_W)) u_rx (
    .field (rx_field),
    .fsel  (rx_fsel),
    .count (rx_count),
    .trig  (rx_trig)
  );

  uft_trig_unit #(.DIR(DIR_TX), .FIELD_W(FIELD_W), .UNIT(UNIT), .CNT_W(CNT_W)) u_tx (
    .field (tx_field),
    .fsel  (tx_fsel),
    .count (tx_space),
    .trig  (tx_trig)
  );

endmodule

// File: rtl/uft_trig_chk.sv
module uft_trig_chk #(
  parameter int FIFO_DEPTH = 64,
  parameter int FIELD_W    = 4,
  parameter int UNIT       = 4,
  parameter int CNT_W      = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_wr,
  input logic [2*FIELD_W-1:0] cfg_wdata,
  input logic                 feat_en,
  input logic                 bank_sel,
  input logic [CNT_W-1:0]     rx_count,
  input logic [CNT_W-1:0]     tx_space,
  input logic                 rx_trig,
  input logic                 tx_trig,
  input logic [2*FIELD_W-1:0] cfg_q
);

  localparam int MAX_LVL = ((1 << FIELD_W) - 1) * UNIT;

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> cfg_q == '0);

  a_r9_gated_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && feat_en && bank_sel) |=> $stable(cfg_q));

  a_r10_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && feat_en && bank_sel) |=> cfg_q == $past(cfg_wdata));

  a_r7_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count == '0 |-> !rx_trig);

  a_r7_high_fires: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rx_count) >= MAX_LVL |-> rx_trig);

  a_r8_full_fires: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_space) == FIFO_DEPTH |-> tx_trig);

  a_r8_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_space) < UNIT |-> !tx_trig);

  a_r3_rx_prog: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[2*FIELD_W-1:FIELD_W] != '0 |->
      rx_trig == (int'(rx_count) >= int'(cfg_q[2*FIELD_W-1:FIELD_W]) * UNIT));

  a_r4_tx_prog: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[FIELD_W-1:0] != '0 |->
      tx_trig == (int'(tx_space) >= int'(cfg_q[FIELD_W-1:0]) * UNIT));

endmodule

bind uart_fifo_trig_sel uft_trig_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .FIELD_W    (FIELD_W),
  .UNIT       (UNIT),
  .CNT_W      (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_wdata (cfg_wdata),
  .feat_en   (feat_en),
  .bank_sel  (bank_sel),
  .rx_count  (rx_count),
  .tx_space  (tx_space),
  .rx_trig   (rx_trig),
  .tx_trig   (tx_trig),
  .cfg_q     (trig_cfg_q)
);

// File: tb/tb_uart_fifo_trig_sel.sv
`timescale 1ns/100ps
module tb_uart_fifo_trig_sel;

  logic       clk;
  logic       rst_n;
  logic       cfg_wr;
  logic [7:0] cfg_wdata;
  logic       feat_en;
  logic       bank_sel;
  logic [1:0] rx_fsel;
  logic [1:0] tx_fsel;
  logic [6:0] rx_count;
  logic [6:0] tx_space;
  logic       rx_trig;
  logic       tx_trig;

  int checks;
  int errors;
  int model_cfg;

  uart_fifo_trig_sel dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .feat_en(feat_en), .bank_sel(bank_sel), .rx_fsel(rx_fsel), .tx_fsel(tx_fsel),
    .rx_count(rx_count), .tx_space(tx_space), .rx_trig(rx_trig), .tx_trig(tx_trig)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference register: written at the rising edge only when fully unlocked.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_cfg <= 0;
    else if (cfg_wr && feat_en && bank_sel) model_cfg <= int'(cfg_wdata);
  end

  function automatic int rx_level(int cfg, int code);
    int f;
    f = (cfg >> 4) & 15;
    if (f != 0) return f * 4;
    case (code)
      0: return 8;
      1: return 16;
      2: return 56;
      default: return 60;
    endcase
  endfunction

  function automatic int tx_level(int cfg, int code);
    int f;
    f = cfg & 15;
    if (f != 0) return f * 4;
    case (code)
      0: return 8;
      1: return 16;
      2: return 32;
      default: return 56;
    endcase
  endfunction

  task automatic check_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (cfg=%02h rx_count=%0d tx_space=%0d rx_fsel=%0d tx_fsel=%0d)",
               req, what, act, exp, model_cfg, rx_count, tx_space, rx_fsel, tx_fsel);
    end
  endtask

  // Drive at the falling edge, compare shortly after.
  task automatic step(string req, int rc, int ts, int rs, int tsel);
    @(negedge clk);
    rx_count = 7'(rc);
    tx_space = 7'(ts);
    rx_fsel  = 2'(rs);
    tx_fsel  = 2'(tsel);
    #1;
    check_bit(req, "rx_trig", rx_trig, logic'(rc >= rx_level(model_cfg, rs)));
    check_bit(req, "tx_trig", tx_trig, logic'(ts >= tx_level(model_cfg, tsel)));
  endtask

  task automatic write_cfg(logic [7:0] v, logic w, logic a, logic b);
    @(negedge clk);
    cfg_wdata = v;
    cfg_wr    = w;
    feat_en   = a;
    bank_sel  = b;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  // Probe each level boundary for the current register.
  task automatic edges(string req);
    for (int c = 0; c < 4; c++) begin
      int rl;
      int tl;
      rl = rx_level(model_cfg, c);
      tl = tx_level(model_cfg, c);
      step(req, rl - 1, tl - 1, c, c);
      step(req, rl, tl, c, c);
    end
  endtask

  initial begin : watchdog
    #(5ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    cfg_wr = 1'b0; cfg_wdata = 8'h00; feat_en = 1'b0; bank_sel = 1'b0;
    rx_fsel = 2'd0; tx_fsel = 2'd0; rx_count = 7'd0; tx_space = 7'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1, R5, R6: reset state uses fallback levels at every code.
    edges("R1");
    step("R5", 56, 0, 2, 0);
    step("R5", 59, 0, 3, 0);
    step("R6", 0, 32, 0, 2);
    step("R6", 0, 31, 0, 2);

    // R9: blocked writes leave fallback levels in place.
    write_cfg(8'hFF, 1'b1, 1'b0, 1'b1);
    edges("R9");
    write_cfg(8'hFF, 1'b1, 1'b1, 1'b0);
    edges("R9");
    write_cfg(8'hFF, 1'b0, 1'b1, 1'b1);
    edges("R9");

    // R2, R3, R4, R10: programmed fields override, per direction.
    write_cfg(8'h31, 1'b1, 1'b1, 1'b1);
    edges("R3");
    step("R2", 12, 4, 3, 3);
    step("R2", 11, 3, 0, 0);
    write_cfg(8'h05, 1'b1, 1'b1, 1'b1);
    edges("R4");
    write_cfg(8'hF0, 1'b1, 1'b1, 1'b1);
    edges("R2");
    step("R7", 60, 64, 0, 0);
    step("R7", 59, 0, 1, 1);
    write_cfg(8'h1F, 1'b1, 1'b1, 1'b1);
    step("R10", 4, 60, 3, 3);
    step("R10", 3, 59, 3, 3);
    edges("R8");

    // R7, R8: spread of counts and codes against the model.
    for (int i = 0; i < 300; i++) begin
      if (i % 25 == 0)
        write_cfg(8'($urandom), 1'b1, 1'($urandom), 1'($urandom));
      step(((i & 1) != 0) ? "R8" : "R7", int'($urandom % 65), int'($urandom % 65),
           int'($urandom % 4), int'($urandom % 4));
    end

    // R1: reset again returns to fallback.
    write_cfg(8'h77, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    edges("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule